// File: doc/BRIEF.md
# Dual/Single Link Pixel Router

This block takes parallel RGB pixels, together with their line and frame timing flags, and hands them to two downstream serializer links. A mode word sets how many pixels arrive per input beat (one or two) and how many links carry them (one or two). From this the router pairs, splits or passes pixels through, so that each link receives a pixel stream in a defined order. Each pixel on a link is tagged with the timing flags that arrived with it.

The input is a valid/ready stream. One input beat carries a first-pixel word, a second-pixel word and the shared flags. In single-input modes the second-pixel word is not used. On the output side both links move in lockstep through one registered output stage with a single shared ready, so the two link strobes never drift apart. A link's valid strobe acts as the clock enable of its serializer, and this is how rate conversion happens inside one fast clock domain. Back-pressure follows the usual rules. An input beat transfers in a cycle where `in_vld` and `in_rdy` are both high. An output beat transfers when `out_rdy` is high. While an output beat is valid and `out_rdy` is low, every output port holds its value. The configuration pins are captured only while reset is held. A swap setting maps logical link 1 to physical port 1 and link 2 to port 0, and it raises `lane_rev`, which tells the serializers to reverse lane order and polarity.

Top module: `pix_link_router`

## Requirements
- R1: Mode 2'b00 (two in, two out): each accepted beat gives one output beat carrying the first pixel on logical link 1 and the second pixel on logical link 2.
- R2: Mode 2'b01 (two in, one out): each accepted beat gives two output beats on link 1, the first pixel and then the second pixel. `in_rdy` is low in the cycle after an accepted beat.
- R3: Mode 2'b10 (one in, two out): accepted pixels form pairs. The earlier pixel of a pair goes on link 1 and the later one on link 2, in one output beat per two pixels, so the first pixel after DE rises lands on link 1.
- R4: Mode 2'b10: if a new pixel's DE differs from the DE of the waiting pixel, the waiting pixel leaves on link 1 beside a pad on link 2 (RGB zero, DE 0, HS/VS copied from the waiting pixel). The new pixel then starts the next pair.
- R5: Mode 2'b11 (one in, one out): each accepted beat gives one output beat with the first pixel on link 1. The second-pixel word is ignored.
- R6: Every output pixel carries the HS, VS and DE of the input beat it came from.
- R7: In the single-output modes (mode bit 0 = 1), logical link 2 has its valid low and its RGB and flags zero.
- R8: `cfg_mode` and `cfg_flip` are captured only while `rst_n` is low. Changes made after reset have no effect.
- R9: With the swap setting captured as 1, logical link 1 appears on port `p1_*`, link 2 appears on `p0_*`, and `lane_rev` is 1. With 0 the mapping is direct and `lane_rev` is 0.
- R10: While any port valid is high and `out_rdy` is low, all output ports hold their value. Every pixel reaches the output exactly once. `in_rdy` is low whenever the block cannot take a beat.
- R11: While reset is held, both port valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_mode | input | 2 | Mode: 00 two/two, 01 two/one, 10 one/two, 11 one/one |
| cfg_flip | input | 1 | Swap logical links onto the opposite ports |
| in_vld | input | 1 | Input beat valid |
| in_rdy | output | 1 | Input beat accepted when high with in_vld |
| in_pa_rgb | input | 3*CW | First-pixel RGB (R high, B low) |
| in_pb_rgb | input | 3*CW | Second-pixel RGB |
| in_hs | input | 1 | Line sync flag of the beat |
| in_vs | input | 1 | Frame sync flag of the beat |
| in_de | input | 1 | Active-data flag of the beat |
| out_rdy | input | 1 | Shared output ready for both links |
| p0_vld | output | 1 | Port 0 pixel strobe |
| p0_rgb | output | 3*CW | Port 0 RGB |
| p0_hs | output | 1 | Port 0 line sync |
| p0_vs | output | 1 | Port 0 frame sync |
| p0_de | output | 1 | Port 0 data enable |
| p1_vld | output | 1 | Port 1 pixel strobe |
| p1_rgb | output | 3*CW | Port 1 RGB |
| p1_hs | output | 1 | Port 1 line sync |
| p1_vs | output | 1 | Port 1 frame sync |
| p1_de | output | 1 | Port 1 data enable |
| lane_rev | output | 1 | Tells serializers to reverse lane order and polarity |

## Verification
The internal state worth attacking is the held pixel used for pairing and splitting, together with the captured mode. A held pixel that is dropped, duplicated or left stale shows up at the very next output beat as a wrong RGB or flag on one link, or as a link that swaps positions in its pair. It also shifts the total beat count by one by the end of the line. A mode or swap latch that follows the pins after reset changes the port mapping or the beat count within a few cycles of release. The output stage is checked on every stalled cycle, so a register that loads while `out_rdy` is low is reported on that same cycle.

// File: rtl/pix_link_router_pkg.sv
package pix_link_router_pkg;
  typedef enum logic [1:0] {
    MD_DD = 2'b00,
    MD_DS = 2'b01,
    MD_SD = 2'b10,
    MD_SS = 2'b11
  } rmode_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;

  localparam int NLINK = 2;
endpackage

// File: rtl/rtr_cfg.sv
module rtr_cfg
  import pix_link_router_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_flip,
  output rmode_e     mode_q,
  output logic       flip_q
);
  // configuration follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= rmode_e'(cfg_mode);
      flip_q <= cfg_flip;
    end
  end
endmodule

// File: rtl/rtr_pack.sv
module rtr_pack
  import pix_link_router_pkg::*;
#(
  parameter int RGBW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rmode_e          mode,
  input  logic            in_vld,
  output logic            in_rdy,
  input  logic [RGBW-1:0] in_pa,
  input  logic [RGBW-1:0] in_pb,
  input  sync_t           in_sy,
  input  logic            adv,
  output logic            emit,
  output logic [RGBW-1:0] e1_rgb,
  output sync_t           e1_sy,
  output logic [RGBW-1:0] e2_rgb,
  output sync_t           e2_sy,
  output logic            e2_en
);
  logic            pend_vld;
  logic [RGBW-1:0] pend_rgb, pend_rgb_n;
  sync_t           pend_sy;
  logic            pend_ld, pend_clr;

  always_comb begin
    in_rdy     = 1'b0;
    emit       = 1'b0;
    e1_rgb     = in_pa;
    e1_sy      = in_sy;
    e2_rgb     = in_pb;
    e2_sy      = in_sy;
    e2_en      = 1'b0;
    pend_ld    = 1'b0;
    pend_clr   = 1'b0;
    pend_rgb_n = in_pa;
    unique case (mode)
      MD_DD: begin
        in_rdy = adv;
        emit   = in_vld && adv;
        e2_en  = 1'b1;
      end
      MD_SS: begin
        in_rdy = adv;
        emit   = in_vld && adv;
      end
      MD_DS: begin
        if (pend_vld) begin
          emit     = adv;
          e1_rgb   = pend_rgb;
          e1_sy    = pend_sy;
          pend_clr = adv;
        end else begin
          in_rdy     = adv;
          emit       = in_vld && adv;
          pend_ld    = in_vld && adv;
          pend_rgb_n = in_pb;
        end
      end
      MD_SD: begin
        e2_en  = 1'b1;
        e1_rgb = pend_rgb;
        e1_sy  = pend_sy;
        e2_rgb = in_pa;
        if (!pend_vld) begin
          in_rdy  = 1'b1;
          pend_ld = in_vld;
        end else begin
          in_rdy = adv;
          emit   = in_vld && adv;
          if (in_sy.de == pend_sy.de) begin
            pend_clr = in_vld && adv;
          end else begin
            e2_rgb  = '0;
            e2_sy   = '{hs: pend_sy.hs, vs: pend_sy.vs, de: 1'b0};
            pend_ld = in_vld && adv;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_rgb <= '0;
      pend_sy  <= '0;
    end else if (pend_ld) begin
      pend_vld <= 1'b1;
      pend_rgb <= pend_rgb_n;
      pend_sy  <= in_sy;
    end else if (pend_clr) begin
      pend_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/rtr_ostg.sv
module rtr_ostg
  import pix_link_router_pkg::*;
#(
  parameter int RGBW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flip,
  input  logic            out_rdy,
  output logic            adv,
  input  logic            emit,
  input  logic [RGBW-1:0] e1_rgb,
  input  sync_t           e1_sy,
  input  logic [RGBW-1:0] e2_rgb,
  input  sync_t           e2_sy,
  input  logic            e2_en,
  output logic            ph_vld [NLINK],
  output logic [RGBW-1:0] ph_rgb [NLINK],
  output sync_t           ph_sy  [NLINK]
);
  logic            ovld;
  logic            o2en;
  logic [RGBW-1:0] lg_rgb [NLINK];
  sync_t           lg_sy  [NLINK];
  logic            lg_vld [NLINK];

  assign adv = !ovld || out_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovld <= 1'b0;
      o2en <= 1'b0;
      for (int i = 0; i < NLINK; i++) begin
        lg_rgb[i] <= '0;
        lg_sy[i]  <= '0;
      end
    end else if (adv) begin
      ovld <= emit;
      if (emit) begin
        o2en      <= e2_en;
        lg_rgb[0] <= e1_rgb;
        lg_sy[0]  <= e1_sy;
        lg_rgb[1] <= e2_en ? e2_rgb : '0;
        lg_sy[1]  <= e2_en ? e2_sy : '0;
      end
    end
  end

  assign lg_vld[0] = ovld;
  assign lg_vld[1] = ovld && o2en;

  for (genvar p = 0; p < NLINK; p++) begin : g_port
    localparam int LDIR = p;
    always_comb begin
      int src;
      src       = flip ? (NLINK - 1 - LDIR) : LDIR;
      ph_vld[p] = lg_vld[src];
      ph_rgb[p] = lg_rgb[src];
      ph_sy[p]  = lg_sy[src];
    end
  end
endmodule

// File: rtl/pix_link_router.sv
module pix_link_router
  import pix_link_router_pkg::*;
#(
  parameter int CW = 8,
  localparam int RGBW = 3 * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_flip,
  input  logic            in_vld,
  output logic            in_rdy,
  input  logic [RGBW-1:0] in_pa_rgb,
  input  logic [RGBW-1:0] in_pb_rgb,
  input  logic            in_hs,
  input  logic            in_vs,
  input  logic            in_de,
  input  logic            out_rdy,
  output logic            p0_vld,
  output logic [RGBW-1:0] p0_rgb,
  output logic            p0_hs,
  output logic            p0_vs,
  output logic            p0_de,
  output logic            p1_vld,
  output logic [RGBW-1:0] p1_rgb,
  output logic            p1_hs,
  output logic            p1_vs,
  output logic            p1_de,
  output logic            lane_rev
);
  rmode_e          mode_q;
  logic            flip_q;
  logic            adv, emit, e2_en;
  logic [RGBW-1:0] e1_rgb, e2_rgb;
  sync_t           e1_sy, e2_sy, in_sy;
  logic            ph_vld [NLINK];
  logic [RGBW-1:0] ph_rgb [NLINK];
  sync_t           ph_sy  [NLINK];

  assign in_sy = '{hs: in_hs, vs: in_vs, de: in_de};

  rtr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_flip(cfg_flip),
    .mode_q(mode_q), .flip_q(flip_q)
  );

  rtr_pack #(.RGBW(RGBW)) u_pack (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .in_vld(in_vld), .in_rdy(in_rdy), .in_pa(in_pa_rgb), .in_pb(in_pb_rgb),
    .in_sy(in_sy), .adv(adv), .emit(emit),
    .e1_rgb(e1_rgb), .e1_sy(e1_sy), .e2_rgb(e2_rgb), .e2_sy(e2_sy), .e2_en(e2_en)
  );

  rtr_ostg #(.RGBW(RGBW)) u_ostg (
    .clk(clk), .rst_n(rst_n), .flip(flip_q), .out_rdy(out_rdy), .adv(adv),
    .emit(emit), .e1_rgb(e1_rgb), .e1_sy(e1_sy), .e2_rgb(e2_rgb), .e2_sy(e2_sy),
    .e2_en(e2_en), .ph_vld(ph_vld), .ph_rgb(ph_rgb), .ph_sy(ph_sy)
  );

  assign p0_vld   = ph_vld[0];
  assign p0_rgb   = ph_rgb[0];
  assign p0_hs    = ph_sy[0].hs;
  assign p0_vs    = ph_sy[0].vs;
  assign p0_de    = ph_sy[0].de;
  assign p1_vld   = ph_vld[1];
  assign p1_rgb   = ph_rgb[1];
  assign p1_hs    = ph_sy[1].hs;
  assign p1_vs    = ph_sy[1].vs;
  assign p1_de    = ph_sy[1].de;
  assign lane_rev = flip_q;
endmodule

// File: rtl/pix_link_router_chk.sv
module pix_link_router_chk
  import pix_link_router_pkg::*;
#(
  parameter int RGBW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input rmode_e          mode_q,
  input logic            flip_q,
  input logic            in_vld,
  input logic            in_rdy,
  input logic            out_rdy,
  input logic            p0_vld,
  input logic            p1_vld,
  input logic [RGBW-1:0] p0_rgb,
  input logic [RGBW-1:0] p1_rgb,
  input logic            p0_de,
  input logic            p1_de
);
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q) && $stable(flip_q)); // R8

  AST_LINK2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |-> !(flip_q ? p0_vld : p1_vld)); // R7

  AST_DUAL_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] |-> (p0_vld == p1_vld)); // R1

  AST_SPLIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_DS) && in_vld && in_rdy |=> !in_rdy); // R2

  AST_HOLD_P0: assert property (@(posedge clk) disable iff (!rst_n)
    p0_vld && !out_rdy |=> p0_vld && $stable(p0_rgb) && $stable(p0_de)); // R10

  AST_HOLD_P1: assert property (@(posedge clk) disable iff (!rst_n)
    p1_vld && !out_rdy |=> p1_vld && $stable(p1_rgb) && $stable(p1_de)); // R10

  AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_SD) && (p0_vld || p1_vld) && !out_rdy |-> !in_rdy); // R10
endmodule

bind pix_link_router pix_link_router_chk #(.RGBW(RGBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .flip_q(flip_q),
  .in_vld(in_vld), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .p0_vld(p0_vld), .p1_vld(p1_vld), .p0_rgb(p0_rgb), .p1_rgb(p1_rgb),
  .p0_de(p0_de), .p1_de(p1_de)
);

// File: tb/pix_link_router_test.sv
module pix_link_router_test;
  localparam int CW = 8;
  localparam int RGBW = 3 * CW;
  localparam int NB = 66;
  localparam int PW = RGBW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_flip = 1'b0;
  logic in_vld = 1'b0;
  logic in_rdy;
  logic [RGBW-1:0] in_pa_rgb = '0, in_pb_rgb = '0;
  logic in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic out_rdy = 1'b0;
  logic p0_vld, p0_hs, p0_vs, p0_de, p1_vld, p1_hs, p1_vs, p1_de, lane_rev;
  logic [RGBW-1:0] p0_rgb, p1_rgb;

  int errs = 0;
  int nchk = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pix_link_router #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_flip(cfg_flip),
    .in_vld(in_vld), .in_rdy(in_rdy), .in_pa_rgb(in_pa_rgb), .in_pb_rgb(in_pb_rgb),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .out_rdy(out_rdy),
    .p0_vld(p0_vld), .p0_rgb(p0_rgb), .p0_hs(p0_hs), .p0_vs(p0_vs), .p0_de(p0_de),
    .p1_vld(p1_vld), .p1_rgb(p1_rgb), .p1_hs(p1_hs), .p1_vs(p1_vs), .p1_de(p1_de),
    .lane_rev(lane_rev)
  );

  // pixel packing used by the bench: {rgb, hs, vs, de}
  function automatic logic [PW-1:0] pix_a(int k);
    logic [7:0] b;
    logic de;
    b  = k[7:0];
    de = (k % 11) >= (((k / 11) % 2) == 1 ? 3 : 4);
    return {b, b ^ 8'h5A, b + 8'd3, (k % 11) == 0, (k % 33) < 2, de};
  endfunction

  function automatic logic [PW-1:0] pix_b(int k);
    logic [PW-1:0] a;
    a = pix_a(k);
    return {~a[PW-1:3], a[2:0]};
  endfunction

  logic [PW-1:0] e1q[$], e2q[$];
  bit enq[$];

  task automatic build_exp(int m);
    logic [PW-1:0] pp, cur;
    bit pv;
    e1q.delete(); e2q.delete(); enq.delete();
    pv = 0; pp = '0;
    for (int k = 0; k < NB; k++) begin
      cur = pix_a(k);
      case (m)
        0: begin e1q.push_back(cur); e2q.push_back(pix_b(k)); enq.push_back(1); end
        1: begin
          e1q.push_back(cur); e2q.push_back('0); enq.push_back(0);
          e1q.push_back(pix_b(k)); e2q.push_back('0); enq.push_back(0);
        end
        2: begin
          if (!pv) begin pp = cur; pv = 1; end
          else if (cur[0] == pp[0]) begin
            e1q.push_back(pp); e2q.push_back(cur); enq.push_back(1); pv = 0;
          end else begin
            e1q.push_back(pp); e2q.push_back({{RGBW{1'b0}}, pp[2], pp[1], 1'b0});
            enq.push_back(1); pp = cur;
          end
        end
        default: begin e1q.push_back(cur); e2q.push_back('0); enq.push_back(0); end
      endcase
    end
  endtask

  task automatic chk(bit ok, string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(int m, bit f);
    logic [PW-1:0] obs [2];
    logic ov [2];
    logic [PW-1:0] prv [2];
    logic pv0, pv1;
    bit stalled;
    int k, nrec;
    string mtag;
    build_exp(m);
    case (m)
      0: mtag = "R1";
      1: mtag = "R2";
      2: mtag = "R3";
      default: mtag = "R5";
    endcase
    rst_n = 1'b0; cfg_mode = 2'(m); cfg_flip = f; in_vld = 1'b0; out_rdy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!p0_vld && !p1_vld, "R11", {26'b0, p0_vld}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lane_rev == f, "R9", {26'b0, lane_rev}, {26'b0, f});
    cfg_mode = ~2'(m); cfg_flip = ~f;
    k = 0; nrec = 0; stalled = 0; prv[0] = '0; prv[1] = '0; pv0 = 0; pv1 = 0;
    for (int t = 0; t < 600; t++) begin
      @(negedge clk);
      cyc++;
      if (k < NB) begin
        out_rdy = ((cyc % 5) != 2) && ((cyc % 7) != 4);
        in_vld = (cyc % 6) != 5;
        {in_pa_rgb, in_hs, in_vs, in_de} = pix_a(k);
        in_pb_rgb = pix_b(k)[PW-1:3];
      end else begin
        out_rdy = 1'b1; in_vld = 1'b0;
        if (t > 560) break;
      end
      #1;
      obs[0] = {p0_rgb, p0_hs, p0_vs, p0_de}; ov[0] = p0_vld;
      obs[1] = {p1_rgb, p1_hs, p1_vs, p1_de}; ov[1] = p1_vld;
      if (stalled) begin
        chk(ov[0] == pv0 && ov[1] == pv1 && obs[0] == prv[0] && obs[1] == prv[1],
            "R10 hold", obs[0], prv[0]);
      end
      if (in_vld && in_rdy) k++;
      if (ov[f] && out_rdy) begin
        if (nrec < e1q.size()) begin
          chk(obs[f][PW-1:3] == e1q[nrec][PW-1:3], f ? "R9" : mtag, obs[f], e1q[nrec]);
          chk(obs[f][2:0] == e1q[nrec][2:0], "R6", obs[f], e1q[nrec]);
          if (enq[nrec]) begin
            chk(ov[!f] == 1'b1, "R1 link2 strobe", {26'b0, ov[!f]}, 27'd1);
            chk(obs[!f] == e2q[nrec], (m == 2 && !e2q[nrec][0]) ? "R4" : mtag,
                obs[!f], e2q[nrec]);
          end else begin
            chk(ov[!f] == 1'b0 && obs[!f] == '0, "R7", obs[!f], '0);
          end
        end else begin
          chk(1'b0, "R10 extra beat", obs[f], '0);
        end
        nrec++;
      end
      stalled = (ov[0] || ov[1]) && !out_rdy;
      prv[0] = obs[0]; prv[1] = obs[1]; pv0 = ov[0]; pv1 = ov[1];
    end
    chk(nrec == e1q.size(), "R10 beat count", PW'(nrec), PW'(e1q.size()));
    chk(lane_rev == f, "R8", {26'b0, lane_rev}, {26'b0, f});
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk + 1);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 2; f++) begin
        run(m, f[0]);
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule